// File: doc/BRIEF.md
# Programmable Progressive Output Timing Generator

This block produces the horizontal and vertical timing of a progressive output raster. A pixel counter and a line counter run on the output pixel clock. The leading edge of the input horizontal sync restarts the pixel counter, and the leading edge of the input vertical sync restarts the line counter. If no input hsync arrives, the pixel counter wraps at a programmed horizontal total and the raster keeps running on its own.

Each output is decoded from the counters by comparing them against programmed half-open windows. The sync window drives the output syncs, whose polarity can be selected. The blanking window drives the blank/reference strobe. The capture windows drive display-enable. Unblanked pixels that fall outside the capture windows are border pixels, and they carry a programmable 24-bit fill color. The counters are also exported for downstream blocks.

Configuration arrives over a simple write port (`cfg_we_i`, `cfg_addr_i`, `cfg_data_i`) and lands in shadow registers. All shadow registers move into the working set together at frame start, so a frame is never torn.

Top module: `prog_raster_gen`

## Requirements
- R1: The pixel counter becomes 0 on the clock edge that samples the input hsync leading edge. The leading edge is the move into the active level, and CTRL (index 0) bit 0 sets that level: 1 = active high, 0 = active low.
- R2: With no hsync edge, the pixel counter counts up by 1 each clock and goes to 0 after reaching total-1. The total is {HTOT_HI(index 1)[7:0], HTOT_LO(index 2)[1:0], 1'b0}, so it is always even. A total of 0 wraps after 2047.
- R3: The line counter counts up by 1 at each line end (an hsync edge or a pixel wrap) and wraps from 1023 to 0. It becomes 0 on an input vsync leading edge, whose active level is set by CTRL bit 1 in the same encoding as R1.
- R4: hsync_o is active while the pixel count is in [index 3, index 4). vsync_o is active while the line count is in [index 9, index 10). CTRL bit 2 (hsync) and CTRL bit 3 (vsync) select the active level: 1 = high, 0 = low.
- R5: blank_o is high while the pixel count is in [index 5, index 6) or the line count is in [index 11, index 12).
- R6: de_o is high when the pixel is unblanked and the pixel count is in [index 7, index 8) and the line count is in [index 13, index 14). border_o is high when the pixel is unblanked and de_o is low. Exactly one of blank_o, de_o and border_o is high at any time.
- R7: While border_o is high, fill_rgb_o equals {index 15, index 16, index 17} as {red, green, blue}. Otherwise it is 0.
- R8: A write changes only a shadow register. The shadow registers are copied to the working set at frame start (an input vsync edge, or a line wrap from 1023 to 0), so a mid-frame write has no effect on the outputs until then.
- R9: During reset both counters are 0 and every register is 0. This gives hsync_o = vsync_o = 1, blank_o = 0, de_o = 0, border_o = 1 and fill_rgb_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_hsync_i | input | 1 | Input horizontal sync |
| in_vsync_i | input | 1 | Input vertical sync |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register index |
| cfg_data_i | input | 16 | Register write data, low bits used |
| hsync_o | output | 1 | Output horizontal sync |
| vsync_o | output | 1 | Output vertical sync |
| blank_o | output | 1 | Blanking/reference strobe |
| de_o | output | 1 | Display enable |
| border_o | output | 1 | Border pixel flag |
| fill_rgb_o | output | 24 | Border fill color, zero outside the border |
| pix_cnt_o | output | 11 | Pixel counter |
| line_cnt_o | output | 10 | Line counter |

## Verification
The assertions check the following on every cycle:
- the pixel counter restarts after an hsync edge;
- the pixel counter steps by one below the total;
- the line counter holds between line ends;
- blank, display-enable and border stay mutually exclusive;
- the working registers stay frozen except at frame start.

Other behaviours can only be shown by the bench's scenarios against its behavioural model:
- exact window placement;
- polarity flips, including a change of input polarity at a frame boundary;
- a mid-frame write that stays invisible until the next vsync;
- the natural 1023-to-0 line wrap.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [4:0] {
    RG_CTRL    = 5'd0,
    RG_HTOT_HI = 5'd1,
    RG_HTOT_LO = 5'd2,
    RG_HS_ON   = 5'd3,
    RG_HS_OFF  = 5'd4,
    RG_HB_ON   = 5'd5,
    RG_HB_OFF  = 5'd6,
    RG_HD_ON   = 5'd7,
    RG_HD_OFF  = 5'd8,
    RG_VS_ON   = 5'd9,
    RG_VS_OFF  = 5'd10,
    RG_VB_ON   = 5'd11,
    RG_VB_OFF  = 5'd12,
    RG_VD_ON   = 5'd13,
    RG_VD_OFF  = 5'd14,
    RG_FILL_R  = 5'd15,
    RG_FILL_G  = 5'd16,
    RG_FILL_B  = 5'd17
  } reg_idx_e;

  localparam int unsigned NUM_REGS   = 18;
  localparam int unsigned CTL_IN_HS  = 0;
  localparam int unsigned CTL_IN_VS  = 1;
  localparam int unsigned CTL_OUT_HS = 2;
  localparam int unsigned CTL_OUT_VS = 3;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int unsigned D_W = 16,
  parameter int unsigned A_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [A_W-1:0]          addr_i,
  input  logic [D_W-1:0]          data_i,
  input  logic                    load_i,
  output logic [NUM_REGS*D_W-1:0] act_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [D_W-1:0] shd_q, act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q <= '0;
        act_q <= '0;
      end else begin
        if (we_i && (addr_i == A_W'(g))) shd_q <= data_i;
        if (load_i) act_q <= shd_q;
      end
    end
    assign act_o[g*D_W +: D_W] = act_q;
  end
endmodule

// File: rtl/raster_edge.sv
module raster_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic pol_i,
  output logic lead_o
);
  logic act, prev_q;

  assign act = pol_i ? sync_i : ~sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= act;
  end

  assign lead_o = act & ~prev_q;
endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_m1;

  // lim 0 means the full binary range
  assign lim_m1 = lim_i - 1'b1;
  assign last_o = (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/raster_window.sv
module raster_window #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] on_i,
  input  logic [W-1:0] off_i,
  output logic         in_o
);
  assign in_o = (cnt_i >= on_i) && (cnt_i < off_i);
endmodule

// File: rtl/prog_raster_gen.sv
module prog_raster_gen
  import raster_pkg::*;
#(
  parameter int unsigned H_W = 11,
  parameter int unsigned V_W = 10,
  parameter int unsigned C_W = 8,
  parameter int unsigned A_W = 5,
  parameter int unsigned D_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_hsync_i,
  input  logic               in_vsync_i,
  input  logic               cfg_we_i,
  input  logic [A_W-1:0]     cfg_addr_i,
  input  logic [D_W-1:0]     cfg_data_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               blank_o,
  output logic               de_o,
  output logic               border_o,
  output logic [3*C_W-1:0]   fill_rgb_o,
  output logic [H_W-1:0]     pix_cnt_o,
  output logic [V_W-1:0]     line_cnt_o
);
  logic [NUM_REGS*D_W-1:0] act;
  logic [3:0]     ctrl;
  logic [H_W-1:0] htot;
  logic [H_W-1:0] h_on  [3];
  logic [H_W-1:0] h_off [3];
  logic [V_W-1:0] v_on  [3];
  logic [V_W-1:0] v_off [3];
  logic [3*C_W-1:0] fill;
  logic hs_lead, vs_lead, h_last, v_last, line_end, frame_start;
  logic [2:0] h_in, v_in;

  raster_regs #(.D_W(D_W), .A_W(A_W)) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .load_i(frame_start), .act_o(act)
  );

  assign ctrl = act[int'(RG_CTRL)*D_W +: 4];
  assign htot = H_W'({act[int'(RG_HTOT_HI)*D_W +: 8], act[int'(RG_HTOT_LO)*D_W +: 2], 1'b0});
  assign fill = {act[int'(RG_FILL_R)*D_W +: C_W], act[int'(RG_FILL_G)*D_W +: C_W],
                 act[int'(RG_FILL_B)*D_W +: C_W]};

  raster_edge u_hs_edge (.clk_i, .rst_ni, .sync_i(in_hsync_i), .pol_i(ctrl[CTL_IN_HS]), .lead_o(hs_lead));
  raster_edge u_vs_edge (.clk_i, .rst_ni, .sync_i(in_vsync_i), .pol_i(ctrl[CTL_IN_VS]), .lead_o(vs_lead));

  raster_counter #(.W(H_W)) u_hcnt (
    .clk_i, .rst_ni, .clr_i(hs_lead), .step_i(1'b1), .lim_i(htot),
    .cnt_o(pix_cnt_o), .last_o(h_last)
  );

  assign line_end = hs_lead | h_last;

  raster_counter #(.W(V_W)) u_vcnt (
    .clk_i, .rst_ni, .clr_i(vs_lead), .step_i(line_end), .lim_i('0),
    .cnt_o(line_cnt_o), .last_o(v_last)
  );

  assign frame_start = vs_lead | (line_end & v_last);

  // window k: 0 sync, 1 blank, 2 capture
  for (genvar k = 0; k < 3; k++) begin : g_win
    assign h_on[k]  = act[(int'(RG_HS_ON) + 2*k)*D_W +: H_W];
    assign h_off[k] = act[(int'(RG_HS_OFF) + 2*k)*D_W +: H_W];
    assign v_on[k]  = act[(int'(RG_VS_ON) + 2*k)*D_W +: V_W];
    assign v_off[k] = act[(int'(RG_VS_OFF) + 2*k)*D_W +: V_W];
    raster_window #(.W(H_W)) u_hw (.cnt_i(pix_cnt_o), .on_i(h_on[k]), .off_i(h_off[k]), .in_o(h_in[k]));
    raster_window #(.W(V_W)) u_vw (.cnt_i(line_cnt_o), .on_i(v_on[k]), .off_i(v_off[k]), .in_o(v_in[k]));
  end

  assign hsync_o    = h_in[0] ~^ ctrl[CTL_OUT_HS];
  assign vsync_o    = v_in[0] ~^ ctrl[CTL_OUT_VS];
  assign blank_o    = h_in[1] | v_in[1];
  assign de_o       = ~blank_o & h_in[2] & v_in[2];
  assign border_o   = ~blank_o & ~de_o;
  assign fill_rgb_o = border_o ? fill : '0;
endmodule

// File: rtl/raster_checker.sv
module raster_checker #(
  parameter int unsigned H_W = 11,
  parameter int unsigned V_W = 10,
  parameter int unsigned C_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hs_lead_i,
  input logic             vs_lead_i,
  input logic             line_end_i,
  input logic             frame_start_i,
  input logic [H_W-1:0]   htot_i,
  input logic [3*C_W-1:0] fill_i,
  input logic [H_W-1:0]   pix_i,
  input logic [V_W-1:0]   line_i,
  input logic             blank_i,
  input logic             de_i,
  input logic             border_i
);
  logic [H_W-1:0] tot_m1;
  assign tot_m1 = htot_i - 1'b1;

  a_r1_hs_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_lead_i |=> (pix_i == '0));

  a_r2_pix_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_lead_i && (pix_i < tot_m1)) |=> (pix_i == $past(pix_i) + 1'b1));

  a_r3_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vs_lead_i && !line_end_i) |=> $stable(line_i));

  a_r6_one_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({blank_i, de_i, border_i}) == 1);

  a_r8_frozen_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ($stable(htot_i) && $stable(fill_i)));
endmodule

bind prog_raster_gen raster_checker #(.H_W(H_W), .V_W(V_W), .C_W(C_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hs_lead_i(hs_lead), .vs_lead_i(vs_lead),
  .line_end_i(line_end), .frame_start_i(frame_start), .htot_i(htot), .fill_i(fill),
  .pix_i(pix_cnt_o), .line_i(line_cnt_o), .blank_i(blank_o), .de_i(de_o), .border_i(border_o)
);

// File: tb/sim_prog_raster_gen.sv
module sim_prog_raster_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_hs = 1'b1, in_vs = 1'b1, we = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] data = '0;
  logic hsync, vsync, blank, de, border;
  logic [23:0] fill;
  logic [10:0] pix;
  logic [9:0] line;

  int checks = 0, errors = 0;
  bit run = 0;
  int shd[18], act[18];
  bit m_ph, m_pv;
  int m_h, m_v;

  always #5 clk = ~clk;

  prog_raster_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_hsync_i(in_hs), .in_vsync_i(in_vs),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_data_i(data),
    .hsync_o(hsync), .vsync_o(vsync), .blank_o(blank), .de_o(de), .border_o(border),
    .fill_rgb_o(fill), .pix_cnt_o(pix), .line_cnt_o(line)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, actual, expected, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (shd[i]) begin shd[i] = 0; act[i] = 0; end
      m_ph = 0; m_pv = 0; m_h = 0; m_v = 0;
    end else begin
      bit ha, va, hl, vl, le, fs;
      int tot, lastp;
      ha = act[0][0] ? in_hs : !in_hs;
      va = act[0][1] ? in_vs : !in_vs;
      hl = ha && !m_ph;
      vl = va && !m_pv;
      tot = act[1] * 8 + act[2] * 2;
      lastp = (tot == 0) ? 2047 : tot - 1;
      le = hl || (m_h >= lastp);
      fs = vl || (le && m_v == 1023);
      m_ph = ha; m_pv = va;
      if (hl || le) m_h = 0; else m_h = m_h + 1;
      if (vl) m_v = 0; else if (le) m_v = (m_v + 1) % 1024;
      if (fs) foreach (act[i]) act[i] = shd[i];
      if (we && addr < 18) shd[addr] = data;
    end
  end

  always @(negedge clk) begin
    if (run) begin
      bit hs, vs, hb, vb, hd, vd, eb, ed, ebo;
      hs = m_h >= act[3] && m_h < act[4];
      hb = m_h >= act[5] && m_h < act[6];
      hd = m_h >= act[7] && m_h < act[8];
      vs = m_v >= act[9] && m_v < act[10];
      vb = m_v >= act[11] && m_v < act[12];
      vd = m_v >= act[13] && m_v < act[14];
      eb = hb || vb;
      ed = !eb && hd && vd;
      ebo = !eb && !ed;
      check("R1/R2 pix", int'(pix), m_h);
      check("R3 line", int'(line), m_v);
      check("R4 hsync", int'(hsync), act[0][2] ? int'(hs) : int'(!hs));
      check("R4 vsync", int'(vsync), act[0][3] ? int'(vs) : int'(!vs));
      check("R5 blank", int'(blank), int'(eb));
      check("R6 de", int'(de), int'(ed));
      check("R6 border", int'(border), int'(ebo));
      check("R7 fill", int'(fill), ebo ? (act[15] * 65536 + act[16] * 256 + act[17]) : 0);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 5'(a); data = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic vpulse(bit lvl);
    @(negedge clk); in_vs = lvl;
    repeat (2) @(negedge clk);
    in_vs = !lvl;
  endtask

  task automatic hpulses(bit lvl, int n, int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_hs = lvl;
      repeat (2) @(negedge clk);
      in_hs = !lvl;
      repeat (period - 3) @(negedge clk);
    end
  endtask

  task automatic wait_pix(int p);
    do @(negedge clk); while (int'(pix) != p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R9 reset values
    check("R9 pix", int'(pix), 0);
    check("R9 line", int'(line), 0);
    check("R9 hsync", int'(hsync), 1);
    check("R9 vsync", int'(vsync), 1);
    check("R9 blank", int'(blank), 0);
    check("R9 de", int'(de), 0);
    check("R9 border", int'(border), 1);
    check("R9 fill", int'(fill), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run = 1;
    // 40-pixel lines
    wr(1, 5); wr(2, 0);
    wr(3, 2); wr(4, 6); wr(5, 0); wr(6, 8); wr(7, 10); wr(8, 34);
    wr(9, 1); wr(10, 2); wr(11, 0); wr(12, 3); wr(13, 5); wr(14, 12);
    wr(15, 8'h12); wr(16, 8'h34); wr(17, 8'h56);
    vpulse(1'b0);
    repeat (400) @(negedge clk);       // R2 free run
    hpulses(1'b0, 12, 25);             // R1 restart before total
    // R8 mid-frame write stays hidden
    wr(3, 20); wr(4, 24);
    wait_pix(3);
    check("R8 old hsync window", int'(hsync), 0);
    wait_pix(21);
    check("R8 new window not yet", int'(hsync), 1);
    vpulse(1'b0);
    wait_pix(3);
    check("R8 after frame start", int'(hsync), 1);
    wait_pix(21);
    check("R8 new window active", int'(hsync), 0);
    // R4 polarity flip, all active high
    wr(0, 4'hF);
    vpulse(1'b0);
    @(negedge clk); in_hs = 1'b0; in_vs = 1'b0;
    repeat (5) @(negedge clk);
    vpulse(1'b1);
    hpulses(1'b1, 8, 30);
    wait_pix(3);
    check("R4 idle high-pol hsync", int'(hsync), 0);
    wait_pix(21);
    check("R4 active high-pol hsync", int'(hsync), 1);
    // R3 natural line wrap with 8-pixel lines
    wr(1, 1); wr(2, 0);
    vpulse(1'b1);
    do @(negedge clk); while (int'(line) != 1023);
    do @(negedge clk); while (int'(line) == 1023);
    check("R3 wrap to zero", int'(line), 0);
    repeat (20) @(negedge clk);
    run = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule